// File: doc/BRIEF.md
# Integer Status and Condition Flags

This block holds the integer exception register (a 32-bit word carrying the summary-overflow, overflow and carry flags plus a 7-bit string byte count) and the condition register, which is split into eight 4-bit fields. Each cycle the integer ALU may present one completed-instruction event. The event carries the result value, the two compare operands, the carry out of the most significant bit, the carry into it, any bits lost by a right shift, an overflow-enable, a record flag, an event kind and a target field number. The block updates the flags and the chosen field from that event. A separate write port loads either register directly.

Bits are numbered big-endian: bit 0 is the most significant bit of each 32-bit word. Field n of the condition register occupies bits 4n to 4n+3, which is vector slice `[31-4n -: 4]`. Inside a field the four flags run, from the most significant bit down, as less-than, greater-than, equal and summary copy. The event input is a plain strobe (`ev_valid`). The block takes an event every cycle and never applies back-pressure, so no ready signal exists. Both registers are visible at all times on `cr_value` and `xer_value`, and every update appears there one clock after the edge that captures it.

Event kind codes on `ev_kind` are: 0 plain, 1 add/subtract/negate, 2 carrying or extended add/subtract, 3 arithmetic right shift, 4 signed compare, 5 unsigned compare, 6 move flags to a condition field.

Top module: `fxflags_unit`

## Requirements
- R1: After reset, `cr_value` and `xer_value` both read zero.
- R2: For kinds 0 to 3 with `ev_rc` high, field 0 becomes {result<0, result>0, result==0, SO after this event}, with the result taken as signed. Exactly one of the first three bits is set. With `ev_rc` low, the condition register is unchanged.
- R3: Kinds 1 and 2 with `ev_oe` high set OV (`xer_value[30]`) to `ev_cout ^ ev_cin_msb`. With `ev_oe` low, OV keeps its value.
- R4: SO (`xer_value[31]`) becomes 1 whenever an event sets OV to 1. Otherwise SO holds its value; only an explicit XER write or kind 6 changes it.
- R5: Kind 2 sets CA (`xer_value[29]`) to `ev_cout`. Kinds 0, 1, 4 and 5 leave CA unchanged.
- R6: Kind 3 sets CA to 1 only when the result is negative and `ev_lost` has any bit set. In every other kind-3 case it clears CA.
- R7: Kind 4 writes {a<b, a>b, a==b, current SO} into field `ev_field`, comparing the operands as two's-complement values. XER is not changed.
- R8: Kind 5 does the same as kind 4 but compares the operands as unsigned values.
- R9: Kind 6 copies XER bits 0..3 ({SO,OV,CA,0}) into field `ev_field` and clears SO, OV and CA in the same cycle. The byte count is kept.
- R10: `wr_xer_en` loads SO, OV, CA and the byte count (`xer_value[6:0]`) from `wr_xer_data`. Reserved bits 3..24 always read zero. In that cycle the explicit write takes priority over any event effect on XER.
- R11: `wr_cr_en` loads every field i whose `wr_cr_mask[i]` is set from the same slice of `wr_cr_data`. This write takes priority over an event that targets the same field.
- R12: A cycle with `ev_valid` low and no write enable leaves both registers unchanged, whatever the other event inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An instruction event is present this cycle |
| ev_kind | input | 3 | Event kind code (0..6) |
| ev_result | input | DW | Result value of the instruction |
| ev_opa | input | DW | First compare operand |
| ev_opb | input | DW | Second compare operand |
| ev_cout | input | 1 | Carry out of the most significant bit |
| ev_cin_msb | input | 1 | Carry into the most significant bit |
| ev_lost | input | DW | Bits shifted out by an arithmetic right shift |
| ev_oe | input | 1 | Overflow recording enabled |
| ev_rc | input | 1 | Record the result into field 0 |
| ev_field | input | $clog2(NFIELD) | Target field for compares and kind 6 |
| wr_xer_en | input | 1 | Explicit XER write |
| wr_xer_data | input | DW | XER write value |
| wr_cr_en | input | 1 | Explicit condition register write |
| wr_cr_mask | input | NFIELD | Per-field write mask |
| wr_cr_data | input | 4*NFIELD | Condition register write value |
| cr_value | output | 4*NFIELD | Condition register |
| xer_value | output | DW | Integer exception register |

## Verification
The bench builds the block with its default parameters: DW = 32, NFIELD = 8 and a 7-bit byte count. This makes every one of the eight fields addressable, so compares can land in the highest and lowest fields, and the field-mask write can hit both ends of the register at once. At the 32-bit width the sign boundary is reachable directly: 0xFFFFFFFF ranks below 1 as a signed value and above it as an unsigned value, and results with the top bit set test negative recording and the shift-carry rule.

// File: rtl/fxflags_pkg.sv
package fxflags_pkg;
  typedef enum logic [2:0] {
    FX_PLAIN = 3'd0,
    FX_ARITH = 3'd1,
    FX_CARRY = 3'd2,
    FX_SRA   = 3'd3,
    FX_CMPS  = 3'd4,
    FX_CMPU  = 3'd5,
    FX_XFER  = 3'd6
  } fx_kind_e;

  localparam int FX_NIB = 4;

  function automatic logic [FX_NIB-1:0] fx_pack(input logic lt, input logic gt,
                                                input logic eq, input logic so);
    return {lt, gt, eq, so};
  endfunction
endpackage

// File: rtl/fx_eval.sv
module fx_eval #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] res,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          is_unsigned,
  input  logic          so_rec,
  input  logic          so_cmp,
  output logic [3:0]    rec_nib,
  output logic [3:0]    cmp_nib
);
  import fxflags_pkg::*;

  logic r_neg, r_zero;
  logic c_lt, c_eq;

  always_comb begin
    r_neg   = res[DW-1];
    r_zero  = (res == '0);
    rec_nib = fx_pack(r_neg, !r_neg && !r_zero, r_zero, so_rec);
  end

  always_comb begin
    c_eq = (opa == opb);
    if (is_unsigned) c_lt = (opa < opb);
    else             c_lt = ($signed(opa) < $signed(opb));
    cmp_nib = fx_pack(c_lt, !c_lt && !c_eq, c_eq, so_cmp);
  end
endmodule

// File: rtl/fx_xer_unit.sv
module fx_xer_unit #(
  parameter int DW  = 32,
  parameter int BCW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic [2:0]    ev_kind,
  input  logic          ev_oe,
  input  logic          ev_cout,
  input  logic          ev_cin_msb,
  input  logic          ev_res_msb,
  input  logic          ev_lost_any,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          so_now,
  output logic          so_after,
  output logic [3:0]    top_nib,
  output logic [DW-1:0] xer_value
);
  import fxflags_pkg::*;

  localparam int RSV = DW - 3 - BCW;

  fx_kind_e kind;
  logic so_q, ov_q, ca_q;
  logic [BCW-1:0] bc_q;
  logic ov_upd, ov_val, ca_upd, ca_val, xfer;
  logic so_ev, ov_ev, ca_ev;

  always_comb begin
    kind   = fx_kind_e'(ev_kind);
    ov_upd = ev_valid && ev_oe && (kind == FX_ARITH || kind == FX_CARRY);
    ov_val = ev_cout ^ ev_cin_msb;
    ca_upd = ev_valid && (kind == FX_CARRY || kind == FX_SRA);
    ca_val = (kind == FX_SRA) ? (ev_res_msb && ev_lost_any) : ev_cout;
    xfer   = ev_valid && (kind == FX_XFER);
    so_ev  = xfer ? 1'b0 : (so_q || (ov_upd && ov_val));
    ov_ev  = xfer ? 1'b0 : (ov_upd ? ov_val : ov_q);
    ca_ev  = xfer ? 1'b0 : (ca_upd ? ca_val : ca_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_q <= 1'b0;
      ov_q <= 1'b0;
      ca_q <= 1'b0;
      bc_q <= '0;
    end else if (wr_en) begin
      so_q <= wr_data[DW-1];
      ov_q <= wr_data[DW-2];
      ca_q <= wr_data[DW-3];
      bc_q <= wr_data[BCW-1:0];
    end else begin
      so_q <= so_ev;
      ov_q <= ov_ev;
      ca_q <= ca_ev;
    end
  end

  assign so_now    = so_q;
  assign so_after  = so_ev;
  assign top_nib   = {so_q, ov_q, ca_q, 1'b0};
  assign xer_value = {so_q, ov_q, ca_q, {RSV{1'b0}}, bc_q};

  p_so_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xer_value[DW-1] && !wr_en && !xfer) |=> xer_value[DW-1]);
  p_ov_sets_so_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ov_upd && ov_val) |=> (xer_value[DW-1] && xer_value[DW-2]));
  p_oe_off_keeps_ov_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !xfer && !ov_upd) |=> $stable(xer_value[DW-2]));
  p_xfer_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && xfer) |=> (xer_value[DW-1:DW-3] == 3'b000 && $stable(xer_value[BCW-1:0])));
  p_cmp_keeps_xer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ev_valid && (kind == FX_CMPS || kind == FX_CMPU)) |=> $stable(xer_value));
endmodule

// File: rtl/fx_cr_unit.sv
module fx_cr_unit #(
  parameter int NFIELD = 8,
  localparam int FIW   = $clog2(NFIELD),
  localparam int CRW   = 4 * NFIELD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [2:0]        ev_kind,
  input  logic [FIW-1:0]    ev_field,
  input  logic              ev_rc,
  input  logic [3:0]        rec_nib,
  input  logic [3:0]        cmp_nib,
  input  logic [3:0]        xfer_nib,
  input  logic              wr_en,
  input  logic [NFIELD-1:0] wr_mask,
  input  logic [CRW-1:0]    wr_data,
  output logic [CRW-1:0]    cr_value
);
  import fxflags_pkg::*;

  fx_kind_e kind;
  logic [3:0] ev_nib;
  logic [FIW-1:0] tgt;
  logic hit;
  logic [3:0] fld [NFIELD];

  always_comb begin
    kind = fx_kind_e'(ev_kind);
    case (kind)
      FX_CMPS, FX_CMPU: begin ev_nib = cmp_nib;  tgt = ev_field; hit = ev_valid; end
      FX_XFER:          begin ev_nib = xfer_nib; tgt = ev_field; hit = ev_valid; end
      FX_PLAIN, FX_ARITH, FX_CARRY, FX_SRA:
                        begin ev_nib = rec_nib;  tgt = '0;       hit = ev_valid && ev_rc; end
      default:          begin ev_nib = rec_nib;  tgt = '0;       hit = 1'b0; end
    endcase
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         fld[g] <= 4'd0;
      else if (wr_en && wr_mask[g])       fld[g] <= wr_data[(NFIELD-1-g)*4 +: 4];
      else if (hit && tgt == FIW'(g))     fld[g] <= ev_nib;
    end
    assign cr_value[(NFIELD-1-g)*4 +: 4] = fld[g];
  end

  p_rec_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !(kind == FX_CMPS || kind == FX_CMPU || kind == FX_XFER) && !(wr_en && wr_mask[0]))
    |=> ($countones(cr_value[CRW-1 -: 3]) == 1));
  p_idle_cr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && !wr_en) |=> $stable(cr_value));
  p_norec_cr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_rc && (kind == FX_PLAIN || kind == FX_ARITH) && !wr_en) |=> $stable(cr_value));
endmodule

// File: rtl/fxflags_unit.sv
module fxflags_unit #(
  parameter int DW     = 32,
  parameter int NFIELD = 8,
  parameter int BCW    = 7,
  localparam int FIW   = $clog2(NFIELD),
  localparam int CRW   = 4 * NFIELD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [2:0]        ev_kind,
  input  logic [DW-1:0]     ev_result,
  input  logic [DW-1:0]     ev_opa,
  input  logic [DW-1:0]     ev_opb,
  input  logic              ev_cout,
  input  logic              ev_cin_msb,
  input  logic [DW-1:0]     ev_lost,
  input  logic              ev_oe,
  input  logic              ev_rc,
  input  logic [FIW-1:0]    ev_field,
  input  logic              wr_xer_en,
  input  logic [DW-1:0]     wr_xer_data,
  input  logic              wr_cr_en,
  input  logic [NFIELD-1:0] wr_cr_mask,
  input  logic [CRW-1:0]    wr_cr_data,
  output logic [CRW-1:0]    cr_value,
  output logic [DW-1:0]     xer_value
);
  import fxflags_pkg::*;

  logic so_now, so_after;
  logic [3:0] top_nib, rec_nib, cmp_nib;

  fx_xer_unit #(.DW(DW), .BCW(BCW)) u_xer (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_oe(ev_oe), .ev_cout(ev_cout), .ev_cin_msb(ev_cin_msb),
    .ev_res_msb(ev_result[DW-1]), .ev_lost_any(|ev_lost),
    .wr_en(wr_xer_en), .wr_data(wr_xer_data),
    .so_now(so_now), .so_after(so_after), .top_nib(top_nib), .xer_value(xer_value)
  );

  fx_eval #(.DW(DW)) u_eval (
    .res(ev_result), .opa(ev_opa), .opb(ev_opb),
    .is_unsigned(ev_kind == 3'(FX_CMPU)),
    .so_rec(so_after), .so_cmp(so_now),
    .rec_nib(rec_nib), .cmp_nib(cmp_nib)
  );

  fx_cr_unit #(.NFIELD(NFIELD)) u_cr (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_field(ev_field), .ev_rc(ev_rc), .rec_nib(rec_nib), .cmp_nib(cmp_nib),
    .xfer_nib(top_nib), .wr_en(wr_cr_en), .wr_mask(wr_cr_mask), .wr_data(wr_cr_data),
    .cr_value(cr_value)
  );

  p_idle_xer_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && !wr_xer_en) |=> $stable(xer_value));
endmodule

// File: tb/sim_fxflags_unit.sv
module sim_fxflags_unit;
  localparam int DW = 32;
  localparam int NF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [2:0] ev_kind = 3'd0;
  logic [DW-1:0] ev_result = '0, ev_opa = '0, ev_opb = '0, ev_lost = '0;
  logic ev_cout = 1'b0, ev_cin_msb = 1'b0, ev_oe = 1'b0, ev_rc = 1'b0;
  logic [2:0] ev_field = 3'd0;
  logic wr_xer_en = 1'b0, wr_cr_en = 1'b0;
  logic [DW-1:0] wr_xer_data = '0;
  logic [NF-1:0] wr_cr_mask = '0;
  logic [4*NF-1:0] wr_cr_data = '0;
  logic [4*NF-1:0] cr_value;
  logic [DW-1:0] xer_value;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_cr = '0;
  logic [31:0] exp_xer = '0;

  always #10 clk = ~clk;

  fxflags_unit u0 (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic both(input string tag);
    chk({tag, " cr"}, cr_value, exp_cr);
    chk({tag, " xer"}, xer_value, exp_xer);
  endtask

  task automatic set_fld(input int i, input logic [3:0] n);
    exp_cr[(NF-1-i)*4 +: 4] = n;
  endtask

  task automatic ev(input logic [2:0] k, input logic [31:0] res, input logic [31:0] a,
                    input logic [31:0] b, input logic co, input logic ci,
                    input logic [31:0] lost, input logic oe, input logic rc, input logic [2:0] f);
    ev_valid = 1'b1; ev_kind = k; ev_result = res; ev_opa = a; ev_opb = b;
    ev_cout = co; ev_cin_msb = ci; ev_lost = lost; ev_oe = oe; ev_rc = rc; ev_field = f;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic wxer(input logic [31:0] d);
    wr_xer_en = 1'b1; wr_xer_data = d;
    @(negedge clk);
    wr_xer_en = 1'b0;
  endtask

  task automatic t_reset;
    both("R1 reset");
  endtask

  task automatic t_xer_write;
    wxer(32'hFFFF_FFFF); exp_xer = 32'hE000_007F; both("R10 all ones");
    wxer(32'h0000_0005); exp_xer = 32'h0000_0005; both("R10 clear flags");
  endtask

  task automatic t_overflow;
    ev(3'd1, 32'h1, 0, 0, 1'b1, 1'b0, 0, 1'b1, 1'b0, 0);
    exp_xer = 32'hC000_0005; both("R3 ov set");
    ev(3'd1, 32'h1, 0, 0, 1'b1, 1'b1, 0, 1'b1, 1'b0, 0);
    exp_xer = 32'h8000_0005; both("R4 so sticky ov clear");
    ev(3'd1, 32'h1, 0, 0, 1'b1, 1'b0, 0, 1'b0, 1'b0, 0);
    both("R3 oe off keeps ov");
  endtask

  task automatic t_record;
    ev(3'd0, 32'h8000_0000, 0, 0, 0, 0, 0, 0, 1'b1, 0);
    set_fld(0, 4'b1001); both("R2 negative");
    ev(3'd0, 32'h0, 0, 0, 0, 0, 0, 0, 1'b1, 0);
    set_fld(0, 4'b0011); both("R2 zero");
    wxer(32'h0);
    exp_xer = 0;
    ev(3'd1, 32'h7FFF_FFFF, 0, 0, 1'b0, 1'b1, 0, 1'b1, 1'b1, 0);
    exp_xer = 32'hC000_0000; set_fld(0, 4'b0101); both("R2 positive so after");
    ev(3'd0, 32'h0, 0, 0, 0, 0, 0, 0, 1'b0, 0);
    both("R2 no record");
  endtask

  task automatic t_carry;
    wxer(32'h0); exp_xer = 0;
    ev(3'd2, 32'h0, 0, 0, 1'b1, 1'b1, 0, 1'b0, 1'b0, 0);
    exp_xer = 32'h2000_0000; both("R5 ca set");
    ev(3'd1, 32'h0, 0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0);
    both("R5 arith keeps ca");
    ev(3'd2, 32'h0, 0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0);
    exp_xer = 32'h0; both("R5 ca clear");
  endtask

  task automatic t_sra;
    ev(3'd3, 32'hF000_0000, 0, 0, 0, 0, 32'h1, 0, 0, 0);
    exp_xer = 32'h2000_0000; both("R6 neg lost");
    ev(3'd3, 32'hF000_0000, 0, 0, 0, 0, 32'h0, 0, 0, 0);
    exp_xer = 32'h0; both("R6 neg none lost");
    ev(3'd3, 32'h0F00_0000, 0, 0, 1'b1, 0, 32'h8000_0000, 0, 0, 0);
    both("R6 pos lost");
  endtask

  task automatic t_compare;
    wxer(32'hA000_0003); exp_xer = 32'hA000_0003;
    ev(3'd4, 0, 32'hFFFF_FFFF, 32'h1, 1'b1, 0, 0, 1'b1, 0, 3'd3);
    set_fld(3, 4'b1001); both("R7 signed lt field3");
    ev(3'd4, 0, 32'h5, 32'h5, 0, 0, 0, 0, 0, 3'd7);
    set_fld(7, 4'b0011); both("R7 signed eq field7");
    ev(3'd5, 0, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0, 0, 3'd2);
    set_fld(2, 4'b0101); both("R8 unsigned gt");
  endtask

  task automatic t_xfer;
    wxer(32'hE000_0011); exp_xer = 32'hE000_0011;
    ev(3'd6, 0, 0, 0, 0, 0, 0, 0, 0, 3'd5);
    set_fld(5, 4'b1110); exp_xer = 32'h0000_0011; both("R9 move flags");
  endtask

  task automatic t_cr_write;
    wr_cr_en = 1'b1; wr_cr_mask = 8'h81; wr_cr_data = 32'h1234_5678;
    ev(3'd4, 0, 32'h1, 32'h2, 0, 0, 0, 0, 0, 3'd0);
    wr_cr_en = 1'b0;
    set_fld(0, 4'h1); set_fld(7, 4'h8); both("R11 masked write wins");
  endtask

  task automatic t_idle;
    ev_kind = 3'd1; ev_oe = 1'b1; ev_cout = 1'b1; ev_rc = 1'b1; ev_result = 32'h8000_0000;
    @(negedge clk); @(negedge clk);
    both("R12 idle");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog got=%08h exp=%08h", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_xer_write();
    t_overflow();
    t_record();
    t_carry();
    t_sra();
    t_compare();
    t_xfer();
    t_cr_write();
    t_idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule